// File: doc/BRIEF.md
# Virtual Register Rename Allocator

This block sits in the rename stage of an out-of-order core whose architected register file is larger than its fast physical value file. Each destination logical register is renamed to a virtual register number (VRN). A VRN has no storage of its own. Its low bits pick one slot of the physical value file directly, and its high bits act as a check tag that a later operand read compares to decide whether the slot still holds the wanted value. The allocator owns a speculative alias table indexed by logical register, a committed copy of that table, a free vector over all VRNs and a free vector over the physical slots.

Every cycle one rename lane may ask for a destination. The allocator grants the lowest-numbered VRN that is free and whose physical slot is free. It marks both busy, records the new mapping and hands back the VRN the logical register held before. The rename stage keeps that previous VRN and presents it again at commit. Commit returns the physical slot at once, returns the previous VRN, and updates the committed map. A flush restores the speculative map from the committed map and returns everything the squashed instructions held. Operand reads, the value files and execution are handled elsewhere.

Top module: `vra_rename_alloc`

## Requirements
- R1: After reset every logical register i maps to VRN i, VRNs 0 to NLR-1 are busy, the other VRNs are free, every physical slot is free, and neither grant nor stall is asserted while no request is made.
- R2: A request with no flush is granted the lowest-numbered VRN that is free and whose physical slot (the VRN's low log2(NPR) bits) is free; grant and VRN are combinational in the request cycle.
- R3: When no such VRN exists the request raises stall for that cycle, no grant is given, and no free state changes unless a commit arrives.
- R4: A grant marks the VRN and its physical slot busy from the next cycle, and returns the logical register's previous VRN; a later rename of the same logical register returns the granted VRN as its previous one.
- R5: A commit frees the physical slot of the committed VRN and frees the previous VRN from the next cycle, and records the committed VRN as the logical register's committed mapping.
- R6: With no commits, at most NPR renames are granted; the next request stalls.
- R7: A flush ignores any rename request in the same cycle, restores every speculative mapping to the committed one, frees every physical slot, and frees every VRN not held by the committed map.
- R8: The VRN's upper bits (the check tag) have no part in choosing the slot: a VRN with a high tag is chosen when every lower VRN sharing a busy slot or itself being busy is passed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request for one destination |
| ren_ldst | input | 8 | Logical destination register of the request |
| ren_grant | output | 1 | Request granted this cycle |
| ren_stall | output | 1 | Request cannot be granted this cycle |
| ren_vrn | output | 9 | Granted VRN |
| ren_prev_vrn | output | 9 | VRN the logical register held before the rename |
| cmt_valid | input | 1 | Oldest in-flight instruction commits |
| cmt_ldst | input | 8 | Logical destination of the committing instruction |
| cmt_vrn | input | 9 | VRN it was granted |
| cmt_prev_vrn | input | 9 | Previous VRN it was given at rename |
| flush | input | 1 | Squash all in-flight instructions |

## Verification
The assertions assume commits arrive in program order, carry exactly the VRN and previous VRN the allocator returned at rename, and never coincide with a flush. The bench keeps an in-order queue of its own grants and commits only the head of that queue, suppresses commit in flush cycles, and forgets the queue on flush. A reference model in the bench, built from the requirements, predicts each grant, stall and previous VRN, while directed steps hit filling all slots, the first VRN with a non-zero tag, and restoration after a flush.

// File: rtl/vra_pkg.sv
// Package: default geometry shared by the rename allocator and its bench.
// Assumes the VRN space exceeds the logical file and the physical file is
// smaller than the logical file.
package vra_pkg;
    localparam int DEF_NLR   = 256;
    localparam int DEF_NPR   = 64;
    localparam int DEF_VRN_W = 9;

    // Kind of update applied to the free state in a cycle.
    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_STEP  = 2'd1,
        UPD_RESTORE = 2'd2
    } upd_kind_e;
endpackage

// File: rtl/vra_pick.sv
// Module: fixed-priority picker, lowest set request index wins.
// Assumes N is a power of two and W = log2(N).
module vra_pick #(
    parameter int N = 512,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    // Scan from the top so the lowest request is the last one written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/vra_alias_table.sv
// Module: speculative and committed alias tables, one VRN per logical register.
// Assumes restore and commit never arrive in the same cycle.
module vra_alias_table #(
    parameter int NLR   = 256,
    parameter int VRN_W = 9,
    localparam int LR_W = $clog2(NLR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LR_W-1:0]  rd_idx,
    output logic [VRN_W-1:0] rd_vrn,
    input  logic             wr_en,
    input  logic [LR_W-1:0]  wr_idx,
    input  logic [VRN_W-1:0] wr_vrn,
    input  logic             cmt_en,
    input  logic [LR_W-1:0]  cmt_idx,
    input  logic [VRN_W-1:0] cmt_vrn,
    input  logic             restore
);
    logic [VRN_W-1:0] spec_q [NLR];
    logic [VRN_W-1:0] arch_q [NLR];

    // Direct-indexed read of the current speculative mapping.
    assign rd_vrn = spec_q[rd_idx];

    // Speculative map: identity at reset, copy of committed map on restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLR; i++) spec_q[i] <= VRN_W'(i);
        end else if (restore) begin
            for (int i = 0; i < NLR; i++) spec_q[i] <= arch_q[i];
        end else if (wr_en) begin
            spec_q[wr_idx] <= wr_vrn;
        end
    end

    // Committed map: follows commits in program order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLR; i++) arch_q[i] <= VRN_W'(i);
        end else if (cmt_en && !restore) begin
            arch_q[cmt_idx] <= cmt_vrn;
        end
    end
endmodule

// File: rtl/vra_free_track.sv
// Module: free vectors for VRNs and physical slots, plus the set of VRNs
// held by committed state (used to rebuild the VRN free vector on flush).
// Assumes allocations target free entries and commits are in order.
module vra_free_track #(
    parameter int NLR   = 256,
    parameter int NPR   = 64,
    parameter int VRN_W = 9,
    localparam int NVR  = 1 << VRN_W,
    localparam int PR_W = $clog2(NPR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vra_pkg::upd_kind_e kind,
    input  logic             alloc_en,
    input  logic [VRN_W-1:0] alloc_vrn,
    input  logic             cmt_en,
    input  logic [VRN_W-1:0] cmt_vrn,
    input  logic [VRN_W-1:0] cmt_prev,
    output logic [NVR-1:0]   vrn_free,
    output logic [NPR-1:0]   phys_free
);
    logic [NVR-1:0] arch_busy_q;

    // Committed ownership: committed VRN becomes held, previous one released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NVR; v++) arch_busy_q[v] <= (v < NLR);
        end else if (kind == vra_pkg::UPD_STEP && cmt_en) begin
            arch_busy_q[cmt_prev] <= 1'b0;
            arch_busy_q[cmt_vrn]  <= 1'b1;
        end
    end

    // VRN free vector: cleared on grant, set on commit, rebuilt on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NVR; v++) vrn_free[v] <= (v >= NLR);
        end else if (kind == vra_pkg::UPD_RESTORE) begin
            vrn_free <= ~arch_busy_q;
        end else if (kind == vra_pkg::UPD_STEP) begin
            if (alloc_en) vrn_free[alloc_vrn] <= 1'b0;
            if (cmt_en)   vrn_free[cmt_prev]  <= 1'b1;
        end
    end

    // Physical slot free vector: reserved on grant, released on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_free <= '1;
        end else if (kind == vra_pkg::UPD_RESTORE) begin
            phys_free <= '1;
        end else if (kind == vra_pkg::UPD_STEP) begin
            if (alloc_en) phys_free[alloc_vrn[PR_W-1:0]] <= 1'b0;
            if (cmt_en)   phys_free[cmt_vrn[PR_W-1:0]]   <= 1'b1;
        end
    end
endmodule

// File: rtl/vra_rename_alloc.sv
// Module: rename allocator top. One lane per cycle: pick a VRN whose own bit
// and whose direct-mapped physical slot are both free, update the alias table,
// release on commit, restore on flush.
// Assumes commit and flush never coincide and commits come in program order.
module vra_rename_alloc #(
    parameter int NLR   = vra_pkg::DEF_NLR,
    parameter int NPR   = vra_pkg::DEF_NPR,
    parameter int VRN_W = vra_pkg::DEF_VRN_W,
    localparam int LR_W = $clog2(NLR),
    localparam int PR_W = $clog2(NPR),
    localparam int NVR  = 1 << VRN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren_valid,
    input  logic [LR_W-1:0]  ren_ldst,
    output logic             ren_grant,
    output logic             ren_stall,
    output logic [VRN_W-1:0] ren_vrn,
    output logic [VRN_W-1:0] ren_prev_vrn,
    input  logic             cmt_valid,
    input  logic [LR_W-1:0]  cmt_ldst,
    input  logic [VRN_W-1:0] cmt_vrn,
    input  logic [VRN_W-1:0] cmt_prev_vrn,
    input  logic             flush
);
    logic [NVR-1:0]     vrn_free;
    logic [NPR-1:0]     phys_free;
    logic [NVR-1:0]     cand;
    logic               cand_any;
    logic [VRN_W-1:0]   cand_idx;
    vra_pkg::upd_kind_e kind;

    // Candidate mask: each VRN qualifies only if its slot is free too.
    for (genvar v = 0; v < NVR; v++) begin : g_cand
        assign cand[v] = vrn_free[v] & phys_free[v % NPR];
    end

    vra_pick #(.N(NVR), .W(VRN_W)) u_pick (
        .req (cand),
        .any (cand_any),
        .idx (cand_idx)
    );

    // Lane decision: flush blocks the lane, otherwise grant or stall.
    always_comb begin
        ren_grant = ren_valid && !flush && cand_any;
        ren_stall = ren_valid && !flush && !cand_any;
        ren_vrn   = cand_idx;
        kind      = flush ? vra_pkg::UPD_RESTORE : vra_pkg::UPD_STEP;
    end

    vra_alias_table #(.NLR(NLR), .VRN_W(VRN_W)) u_rat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (ren_ldst),
        .rd_vrn  (ren_prev_vrn),
        .wr_en   (ren_grant),
        .wr_idx  (ren_ldst),
        .wr_vrn  (cand_idx),
        .cmt_en  (cmt_valid),
        .cmt_idx (cmt_ldst),
        .cmt_vrn (cmt_vrn),
        .restore (flush)
    );

    vra_free_track #(.NLR(NLR), .NPR(NPR), .VRN_W(VRN_W)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .alloc_en  (ren_grant),
        .alloc_vrn (cand_idx),
        .cmt_en    (cmt_valid),
        .cmt_vrn   (cmt_vrn),
        .cmt_prev  (cmt_prev_vrn),
        .vrn_free  (vrn_free),
        .phys_free (phys_free)
    );
endmodule

// File: rtl/vra_checker.sv
// Module: temporal checks on the allocator, bound into every instance.
// Assumes in-order commits that never coincide with a flush.
module vra_checker #(
    parameter int NPR   = 64,
    parameter int VRN_W = 9,
    localparam int NVR  = 1 << VRN_W,
    localparam int PR_W = $clog2(NPR)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ren_valid,
    input logic             ren_grant,
    input logic             ren_stall,
    input logic [VRN_W-1:0] ren_vrn,
    input logic             cmt_valid,
    input logic [VRN_W-1:0] cmt_vrn,
    input logic [VRN_W-1:0] cmt_prev_vrn,
    input logic             flush,
    input logic [NVR-1:0]   vrn_free,
    input logic [NPR-1:0]   phys_free
);
    // Granted VRN and its slot are free at the time of the grant.
    assert_pick_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ren_grant |-> (vrn_free[ren_vrn] && phys_free[ren_vrn[PR_W-1:0]]));

    // A valid request without flush is answered by exactly one of grant/stall.
    assert_lane_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !flush) |-> (ren_grant != ren_stall));

    // Stall with nothing else going on leaves free state untouched.
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_stall && !cmt_valid && !flush) |=> ($stable(vrn_free) && $stable(phys_free)));

    // Grant reserves the VRN and its physical slot.
    assert_alloc_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ren_grant |=> (!vrn_free[$past(ren_vrn)] && !phys_free[$past(ren_vrn[PR_W-1:0])]));

    // Commit releases the slot and the previous VRN.
    assert_commit_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && !flush) |=> (phys_free[$past(cmt_vrn[PR_W-1:0])] && vrn_free[$past(cmt_prev_vrn)]));

    // Flush blocks the lane and frees every physical slot.
    assert_flush_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !ren_grant && !ren_stall);
    assert_flush_slots_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (&phys_free));
endmodule

bind vra_rename_alloc vra_checker #(.NPR(NPR), .VRN_W(VRN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_valid    (ren_valid),
    .ren_grant    (ren_grant),
    .ren_stall    (ren_stall),
    .ren_vrn      (ren_vrn),
    .cmt_valid    (cmt_valid),
    .cmt_vrn      (cmt_vrn),
    .cmt_prev_vrn (cmt_prev_vrn),
    .flush        (flush),
    .vrn_free     (vrn_free),
    .phys_free    (phys_free)
);

// File: tb/tb_vra_rename_alloc.sv
// Bench: directed corners then seeded random traffic, compared against a
// requirement-level model of the maps and free vectors.
module tb_vra_rename_alloc;
    localparam int CLK_PERIOD = 10;
    localparam int NLR = 256;
    localparam int NPR = 64;
    localparam int NVR = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0;
    logic [7:0] ren_ldst = '0;
    logic       ren_grant, ren_stall;
    logic [8:0] ren_vrn, ren_prev_vrn;
    logic       cmt_valid = 1'b0;
    logic [7:0] cmt_ldst = '0;
    logic [8:0] cmt_vrn = '0, cmt_prev_vrn = '0;
    logic       flush = 1'b0;

    int checks = 0;
    int errors = 0;

    // Model state.
    int  m_rat  [NLR];
    int  m_arat [NLR];
    bit  m_vfree[NVR];
    bit  m_pfree[NPR];
    int  q_l[$];
    int  q_v[$];
    int  q_p[$];

    // Last observed outputs.
    bit g_grant, g_stall;
    int g_vrn, g_prev;

    vra_rename_alloc dut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_ldst(ren_ldst),
        .ren_grant(ren_grant), .ren_stall(ren_stall),
        .ren_vrn(ren_vrn), .ren_prev_vrn(ren_prev_vrn),
        .cmt_valid(cmt_valid), .cmt_ldst(cmt_ldst),
        .cmt_vrn(cmt_vrn), .cmt_prev_vrn(cmt_prev_vrn),
        .flush(flush)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model_pick();
        for (int v = 0; v < NVR; v++)
            if (m_vfree[v] && m_pfree[v % NPR]) return v;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NLR; i++) begin m_rat[i] = i; m_arat[i] = i; end
        for (int v = 0; v < NVR; v++) m_vfree[v] = (v >= NLR);
        for (int p = 0; p < NPR; p++) m_pfree[p] = 1'b1;
        q_l.delete(); q_v.delete(); q_p.delete();
    endtask

    // One cycle: drive at negedge, check combinational outputs, update model.
    task automatic cycle(input bit rv, input int rl, input bit cv, input bit fl);
        int exp_v;
        bit do_cmt;
        @(negedge clk);
        do_cmt = cv && !fl && (q_l.size() > 0);
        ren_valid = rv; ren_ldst = 8'(rl); flush = fl;
        cmt_valid = do_cmt;
        if (do_cmt) begin
            cmt_ldst = 8'(q_l[0]); cmt_vrn = 9'(q_v[0]); cmt_prev_vrn = 9'(q_p[0]);
        end
        #1;
        g_grant = ren_grant; g_stall = ren_stall;
        g_vrn = int'(ren_vrn); g_prev = int'(ren_prev_vrn);
        exp_v = model_pick();
        if (fl) begin
            chk(!g_grant && !g_stall, "R7", "flush lane quiet", int'(g_grant), 0);
        end else if (rv) begin
            chk(g_grant == (exp_v >= 0), "R2", "grant", int'(g_grant), int'(exp_v >= 0));
            chk(g_stall == (exp_v < 0), "R3", "stall", int'(g_stall), int'(exp_v < 0));
            chk(g_prev == m_rat[rl], "R4", "prev vrn", g_prev, m_rat[rl]);
            if (exp_v >= 0) chk(g_vrn == exp_v, "R2", "vrn", g_vrn, exp_v);
        end else begin
            chk(!g_grant && !g_stall, "R3", "idle lane quiet", int'(g_grant), 0);
        end
        // Model update.
        if (fl) begin
            for (int i = 0; i < NLR; i++) m_rat[i] = m_arat[i];
            for (int v = 0; v < NVR; v++) m_vfree[v] = 1'b1;
            for (int i = 0; i < NLR; i++) m_vfree[m_arat[i]] = 1'b0;
            for (int p = 0; p < NPR; p++) m_pfree[p] = 1'b1;
            q_l.delete(); q_v.delete(); q_p.delete();
        end else begin
            if (do_cmt) begin
                m_pfree[q_v[0] % NPR] = 1'b1;
                m_vfree[q_p[0]] = 1'b1;
                m_arat[q_l[0]] = q_v[0];
                void'(q_l.pop_front()); void'(q_v.pop_front()); void'(q_p.pop_front());
            end
            if (rv && exp_v >= 0) begin
                q_l.push_back(rl); q_v.push_back(exp_v); q_p.push_back(m_rat[rl]);
                m_vfree[exp_v] = 1'b0;
                m_pfree[exp_v % NPR] = 1'b0;
                m_rat[rl] = exp_v;
            end
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state, idle lane quiet, identity mapping, first free VRN.
        cycle(0, 0, 0, 0);
        chk(!g_grant && !g_stall, "R1", "idle after reset", int'(g_grant), 0);
        cycle(1, 5, 0, 0);
        chk(g_vrn == 256, "R1", "first grant vrn", g_vrn, 256);
        chk(g_prev == 5, "R1", "identity prev", g_prev, 5);

        // R6: fill every physical slot, then the next request stalls.
        for (int i = 0; i < NPR - 1; i++) cycle(1, 10 + i, 0, 0);
        chk(g_vrn == 319, "R6", "last slot vrn", g_vrn, 319);
        cycle(1, 200, 0, 0);
        chk(g_stall && !g_grant, "R6", "stall when full", int'(g_stall), 1);
        cycle(1, 201, 0, 0);
        chk(g_stall, "R3", "stall repeats", int'(g_stall), 1);

        // R5 and R8: commit frees slot 0; only tag 5 VRN 320 fits it.
        cycle(0, 0, 1, 0);
        cycle(1, 9, 0, 0);
        chk(g_grant && g_vrn == 320, "R8", "tag 5 slot 0 vrn", g_vrn, 320);

        // R4: second rename of the same register sees the first grant.
        cycle(0, 0, 1, 0);
        cycle(1, 9, 0, 0);
        chk(g_prev == 320, "R4", "prev after rename", g_prev, 320);
        cycle(0, 0, 1, 0);

        // R7: flush with request, then committed map and freed VRN 5 reappear.
        cycle(1, 7, 0, 1);
        cycle(1, 5, 0, 0);
        chk(g_prev == 256, "R7", "restored prev", g_prev, 256);
        chk(g_grant && g_vrn == 5, "R7", "released vrn reused", g_vrn, 5);

        // Random traffic with occasional flushes.
        for (int n = 0; n < 6000; n++) begin
            bit fl = ($urandom % 100) < 1;
            bit rv = ($urandom % 100) < 60;
            bit cv = ($urandom % 100) < 45;
            cycle(rv, int'($urandom % NLR), cv, fl);
        end
        cycle(0, 0, 0, 0);
        finish_run();
    end
endmodule